// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block holds the interrupt-status logic of a real-time-clock register set. Three event sources feed it: a periodic tick produced by an internal programmable divider, and alarm and update-ended pulses supplied from outside. Each source latches its own flag in a status register whenever it fires. A control register holds one enable per source plus the divider rate code. A sticky summary flag is raised whenever an event flag meets its enable, and it drives an active-high interrupt line.

Software reaches both registers over a simple single-cycle register bus: address 0 is the control register, address 1 the read-only status register. Read data is combinational on the address, and a read strobe to the status register returns its value and clears it. A mode input picks how the line behaves. In strict mode it mirrors the summary flag. In no-acknowledge mode every new interrupt drops the line for one cycle, so an edge-triggered interrupt controller sees a fresh rising edge even when software never reads the status register.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00 and irq is low.
- R2: A bus write (bus_sel=1, bus_we=1, bus_addr=0) stores bits 2:0 (enables: bit0 periodic, bit1 alarm, bit2 update-ended) and bits 7:4 (rate code); reading address 0 returns those bits with bit 3 as 0.
- R3: An alarm_evt pulse sets status bit1 and an update_evt pulse sets status bit2 at the next clock edge, whatever the enables.
- R4: With rate code k in 1..15, status bit0 is set on every base_tick pulse whose count since reset is a multiple of 2^(k-1); code 0 never sets it; the enable bit does not gate it. Code 10 turns a 32768 Hz base into 64 Hz.
- R5: Status bit7 (summary) becomes set at the edge where some event flag and its enable are both set.
- R6: A status read (bus_sel=1, bus_we=0, bus_addr=1) returns the current value, then clears all flags and the summary bit; writes to address 1 change nothing.
- R7: An event arriving in the same cycle as a status read leaves its flag set after the clear.
- R8: The summary bit stays set until a status read, even if later the enables are cleared.
- R9: In strict mode (mode_noack=0) irq equals the summary bit in every cycle.
- R10: In no-acknowledge mode (mode_noack=1), each enabled event, or the enabling of a source whose flag is pending, drives irq low for the following cycle, after which irq returns to the summary bit.
- R11: Writing the control register so that a source with a pending flag becomes enabled sets the summary bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_noack | input | 1 | 1 selects no-acknowledge line behaviour, 0 strict |
| base_tick | input | 1 | One-cycle pulse of the divider's base clock |
| alarm_evt | input | 1 | One-cycle alarm event pulse |
| update_evt | input | 1 | One-cycle update-ended event pulse |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 1 | 0 control, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Interrupt line, active high |

## Verification
The bound checker watches every cycle that the summary bit is sticky outside status reads, that an undisturbed read empties the status register, that a set summary always has a flag behind it, that alarm pulses always land, and that the line never rises without the summary bit and follows it exactly in strict mode. The divider rate, the 64 Hz setting, reads that race an event, the fresh interrupt on enabling a pending source and the one-cycle gap of no-acknowledge mode depend on sequences, so the bench shows them through directed scenarios and a reference model under random traffic.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int NSRC    = 3;
   localparam int SRC_PER = 0;
   localparam int SRC_ALM = 1;
   localparam int SRC_UPD = 2;

   typedef enum logic {
      ADDR_CTRL = 1'b0,
      ADDR_STAT = 1'b1
   } reg_addr_e;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_tick,
   input  logic [SEL_W-1:0] rate_sel,
   output logic             tick
);
   localparam int CNT_W = (1 << SEL_W) - 2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mask;

   // mask has the low (rate_sel-1) bits set
   always_comb begin
      mask = '0;
      for (int i = 0; i < CNT_W; i++) begin
         mask[i] = (32'(rate_sel) > (i + 1));
      end
   end

   assign tick = base_tick && (rate_sel != '0) && ((cnt_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (base_tick) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] en_cur,
   input  logic [N-1:0] en_nxt,
   input  logic         clr,
   output logic [N-1:0] flags,
   output logic         summary,
   output logic         fire
);
   logic [N-1:0] nxt;
   logic [N-1:0] hit;
   logic         sum_q;

   for (genvar i = 0; i < N; i++) begin : g_src
      logic f_q;
      assign nxt[i] = (f_q & ~clr) | evt[i];
      // a new event on an enabled source, or a pending flag whose enable just rose
      assign hit[i] = en_nxt[i] & (evt[i] | (nxt[i] & ~en_cur[i]));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) f_q <= 1'b0;
         else        f_q <= nxt[i];
      end
      assign flags[i] = f_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= 1'b0;
      else        sum_q <= (sum_q & ~clr) | (|(nxt & en_nxt));
   end

   assign summary = sum_q;
   assign fire    = |hit;
endmodule

// File: rtl/rtc_line_shaper.sv
module rtc_line_shaper (
   input  logic clk,
   input  logic rst_n,
   input  logic noack,
   input  logic summary,
   input  logic fire,
   output logic irq
);
   logic fire_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fire_q <= 1'b0;
      else        fire_q <= fire;
   end

   assign irq = summary & ~(noack & fire_q);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
   import rtc_irq_pkg::*;
#(
   parameter int DW    = 8,
   parameter int SEL_W = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_noack,
   input  logic          base_tick,
   input  logic          alarm_evt,
   input  logic          update_evt,
   input  logic          bus_sel,
   input  logic          bus_we,
   input  logic          bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq
);
   localparam int RATE_LSB = DW - SEL_W;

   if (SEL_W < 2 || SEL_W > 5) begin : g_bad_sel
      $error("rtc_irq_ctrl: SEL_W must lie in 2..5");
   end
   if (DW < NSRC + SEL_W + 1) begin : g_bad_dw
      $error("rtc_irq_ctrl: DW too narrow for enables, spare bit and rate code");
   end

   logic [NSRC-1:0]  en_q, en_nxt;
   logic [SEL_W-1:0] rate_q;
   logic             wr_ctrl, rd_stat;
   logic             per_tick, fire;
   logic [NSRC-1:0]  evt;
   logic [NSRC-1:0]  st_flags;
   logic             st_sum;

   assign wr_ctrl = bus_sel &  bus_we & (bus_addr == ADDR_CTRL);
   assign rd_stat = bus_sel & ~bus_we & (bus_addr == ADDR_STAT);
   assign en_nxt  = wr_ctrl ? bus_wdata[NSRC-1:0] : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         rate_q <= '0;
      end else if (wr_ctrl) begin
         en_q   <= bus_wdata[NSRC-1:0];
         rate_q <= bus_wdata[DW-1 -: SEL_W];
      end
   end

   rtc_tick_div #(.SEL_W(SEL_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_tick (base_tick),
      .rate_sel  (rate_q),
      .tick      (per_tick)
   );

   always_comb begin
      evt          = '0;
      evt[SRC_PER] = per_tick;
      evt[SRC_ALM] = alarm_evt;
      evt[SRC_UPD] = update_evt;
   end

   rtc_flag_bank #(.N(NSRC)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .en_cur  (en_q),
      .en_nxt  (en_nxt),
      .clr     (rd_stat),
      .flags   (st_flags),
      .summary (st_sum),
      .fire    (fire)
   );

   rtc_line_shaper u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .noack   (mode_noack),
      .summary (st_sum),
      .fire    (fire),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_STAT) begin
         bus_rdata[NSRC-1:0] = st_flags;
         bus_rdata[DW-1]     = st_sum;
      end else begin
         bus_rdata[NSRC-1:0]       = en_q;
         bus_rdata[DW-1 -: SEL_W]  = rate_q;
      end
   end

   if (RATE_LSB <= NSRC) begin : g_rate_chk
      $error("rtc_irq_ctrl: rate field overlaps enable bits");
   end
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk #(
   parameter int N = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic         mode_noack,
   input logic         base_tick,
   input logic         alarm_evt,
   input logic         update_evt,
   input logic         rd_stat,
   input logic [N-1:0] st_flags,
   input logic         st_sum,
   input logic         irq
);
   // R8
   sum_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_sum && !rd_stat) |=> st_sum);

   // R6
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !alarm_evt && !update_evt && !base_tick) |=> (st_flags == '0 && !st_sum));

   // R5
   sum_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_sum |-> (st_flags != '0));

   // R3
   alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |=> st_flags[1]);

   // R9
   strict_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_noack |-> (irq == st_sum));

   // R10
   line_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> st_sum);
endmodule

bind rtc_irq_ctrl rtc_irq_chk #(.N(rtc_irq_pkg::NSRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_noack (mode_noack),
   .base_tick  (base_tick),
   .alarm_evt  (alarm_evt),
   .update_evt (update_evt),
   .rd_stat    (rd_stat),
   .st_flags   (st_flags),
   .st_sum     (st_sum),
   .irq        (irq)
);

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_noack = 1'b0;
   logic       base_tick = 1'b0, alarm_evt = 1'b0, update_evt = 1'b0;
   logic       bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;

   always #2.5 clk = ~clk;

   rtc_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .mode_noack(mode_noack), .base_tick(base_tick),
      .alarm_evt(alarm_evt), .update_evt(update_evt), .bus_sel(bus_sel),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   logic [2:0]  m_en = '0, m_flags = '0;
   logic [3:0]  m_rate = '0;
   logic        m_sum = 0, m_fire_q = 0;
   logic [15:0] m_bcnt = '0;
   logic [7:0]  rd_seen;
   logic        irq_seen;

   function automatic logic [7:0] exp_rdata(input logic a);
      return a ? {m_sum, 4'b0, m_flags} : {m_rate, 1'b0, m_en};
   endfunction

   function automatic logic exp_irq();
      return m_sum & ~(mode_noack & m_fire_q);
   endfunction

   function automatic logic per_hit(input logic bt);
      logic [15:0] mask;
      if (!bt || m_rate == 0) return 1'b0;
      mask = (16'd1 << (m_rate - 1)) - 16'd1;
      return (m_bcnt & mask) == mask;
   endfunction

   task automatic chk(input string tag, input logic ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one bus cycle: drive, compare with model, advance model
   task automatic cyc(input logic s, input logic w, input logic a, input logic [7:0] d,
                      input logic al, input logic up, input logic bt);
      logic [2:0] evt, nen, nfl;
      logic       rd, wr;
      @(negedge clk);
      bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
      alarm_evt = al; update_evt = up; base_tick = bt;
      #1;
      rd_seen  = bus_rdata;
      irq_seen = irq;
      chk(a ? "R6 status read" : "R2 control read", bus_rdata == exp_rdata(a),
          bus_rdata, exp_rdata(a));
      chk(mode_noack ? "R10 line" : "R9 line", irq == exp_irq(), irq, exp_irq());
      wr  = s & w & ~a;
      rd  = s & ~w & a;
      evt = {up, al, per_hit(bt)};
      nen = wr ? d[2:0] : m_en;
      nfl = (rd ? 3'b0 : m_flags) | evt;
      m_fire_q = |(evt & nen) | |(nfl & nen & ~m_en);
      m_sum    = (rd ? 1'b0 : m_sum) | |(nfl & nen);
      m_flags  = nfl;
      if (wr) begin m_en = d[2:0]; m_rate = d[7:4]; end
      if (bt) m_bcnt = m_bcnt + 16'd1;
   endtask

   task automatic idle();           cyc(0, 0, 1, 8'h00, 0, 0, 0); endtask
   task automatic wr_ctrl(input logic [7:0] d); cyc(1, 1, 0, d, 0, 0, 0); endtask
   task automatic rd_stat();        cyc(1, 0, 1, 8'h00, 0, 0, 0); endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      int seen;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset values
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk("R1 ctrl after reset", rd_seen == 8'h00, rd_seen, 8'h00);
      chk("R1 irq after reset", irq_seen == 1'b0, irq_seen, 0);
      idle();
      chk("R1 status after reset", rd_seen == 8'h00, rd_seen, 8'h00);

      // R2 write/readback
      wr_ctrl(8'hAF);
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk("R2 ctrl readback", rd_seen == 8'hA7, rd_seen, 8'hA7);
      wr_ctrl(8'h00);

      // R3 alarm with enable off
      cyc(0, 0, 1, 0, 1, 0, 0);
      idle();
      chk("R3 alarm flag", rd_seen == 8'h02, rd_seen, 8'h02);
      chk("R5 no summary when disabled", irq_seen == 0, irq_seen, 0);

      // R11 enabling a pending source
      wr_ctrl(8'h02);
      idle();
      chk("R11 summary on enable", rd_seen == 8'h82, rd_seen, 8'h82);
      chk("R9 strict line high", irq_seen == 1, irq_seen, 1);

      // R6 read returns then clears; write to status ignored
      cyc(1, 1, 1, 8'hFF, 0, 0, 0);
      idle();
      chk("R6 write to status ignored", rd_seen == 8'h82, rd_seen, 8'h82);
      rd_stat();
      chk("R6 read value", rd_seen == 8'h82, rd_seen, 8'h82);
      idle();
      chk("R6 cleared", rd_seen == 8'h00, rd_seen, 8'h00);

      // R8 sticky after enables drop
      cyc(0, 0, 1, 0, 1, 0, 0);
      wr_ctrl(8'h00);
      idle();
      chk("R8 summary sticky", rd_seen == 8'h82, rd_seen, 8'h82);

      // R7 event racing a read
      cyc(1, 0, 1, 0, 0, 1, 0);
      idle();
      chk("R7 update survives read", rd_seen == 8'h04, rd_seen, 8'h04);
      rd_stat();

      // R4 rate 0: no periodic flag
      seen = 0;
      for (int i = 0; i < 8; i++) begin
         cyc(0, 0, 1, 0, 0, 0, 1);
         idle();
         if (rd_seen[0]) begin seen++; rd_stat(); end
      end
      chk("R4 code 0 silent", seen == 0, seen, 0);

      // R4 rate 3: one flag per 4 pulses, enable off
      wr_ctrl(8'h30);
      seen = 0;
      for (int i = 0; i < 16; i++) begin
         cyc(0, 0, 1, 0, 0, 0, 1);
         idle();
         if (rd_seen[0]) begin
            seen++;
            chk("R4 no summary without enable", rd_seen == 8'h01, rd_seen, 8'h01);
            rd_stat();
         end
      end
      chk("R4 code 3 count", seen == 4, seen, 4);

      // R4 64 Hz: code 10, 512 pulses per tick
      wr_ctrl(8'hA0);
      seen = 0;
      for (int i = 0; i < 1024; i++) begin
         cyc(0, 0, 1, 0, 0, 0, 1);
         if (rd_seen[0]) begin seen++; rd_stat(); end
      end
      idle();
      if (rd_seen[0]) seen++;
      chk("R4 64 Hz count", seen == 2, seen, 2);
      rd_stat();

      // R10 no-ack gaps, status never read
      mode_noack = 1'b1;
      wr_ctrl(8'h11);
      cyc(0, 0, 1, 0, 0, 0, 1);
      idle();
      chk("R10 first gap", irq_seen == 0, irq_seen, 0);
      idle();
      chk("R10 line up", irq_seen == 1, irq_seen, 1);
      cyc(0, 0, 1, 0, 0, 0, 1);
      idle();
      chk("R10 second gap", irq_seen == 0, irq_seen, 0);
      idle();
      chk("R10 line up again", irq_seen == 1, irq_seen, 1);
      rd_stat();
      mode_noack = 1'b0;

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         logic s, w, a;
         logic [7:0] d;
         if (i % 700 == 0) mode_noack = $urandom_range(1);
         s = ($urandom_range(9) < 3);
         w = $urandom_range(1);
         a = $urandom_range(1);
         d = 8'($urandom_range(255));
         d[7:4] = 4'($urandom_range(4));
         cyc(s, w, a, d, $urandom_range(19) == 0, $urandom_range(19) == 0,
             $urandom_range(9) < 3);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule